// File: doc/BRIEF.md
# GPIO Interrupt Aggregation Unit

The unit takes a bank of general-purpose input lines from board-level interrupt sources and turns them into one registered interrupt request for an upstream interrupt controller. It behaves as a cleaned-up pass-through wire. Each line is brought into the clock domain by a two-flop synchroniser. It can then be filtered by a debounce stage that needs a programmable number of stable prescaler ticks. After that it is classified as level-sensitive or edge-sensitive with a selectable polarity.

Software programs the unit through a simple register read/write port. The enable and mask registers are independent. A line reaches the combined request only when it is enabled and not masked. Raw and masked status can be read back. Latched edge events are cleared by writing ones to an end-of-interrupt register. A typical start-up sequence masks every line, unmasks the used lines, selects the detection type and polarity, and finally enables only the connected lines (for example lines 0, 2 and 3, value 0x0D).

Each line's debounce filter is a two-state machine:
- DB_STABLE: the accepted value matches the synchronised input.
- DB_SETTLE: the synchronised input differs from the accepted value and ticks are being counted.

Transitions:
- "mismatch" moves DB_STABLE to DB_SETTLE.
- "glitch" returns DB_SETTLE to DB_STABLE when the input reverts before the count is reached. The accepted value is unchanged.
- "accept" returns DB_SETTLE to DB_STABLE when the count is reached, and takes the new value.
- "bypass" forces DB_STABLE from either state when debounce is off for the line.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset every configuration register reads 0, raw and masked status read 0 and `irq_o` is 0. Lines start disabled, unmasked, level-sensitive, active-low and without debounce.
- R2: Register map. The following registers are read/write and hold one bit per line:
  - enable at 0x30
  - mask at 0x34
  - type at 0x38
  - polarity at 0x3C
  - debounce-enable at 0x48

  The tick divider at 0x50 keeps its low 16 bits. The debounce length at 0x54 keeps its low 8 bits. End-of-interrupt at 0x4C reads 0, and so does any unmapped offset.
- R3: A line contributes to `irq_o` only when its enable bit is 1 and its mask bit is 0. Masked status at 0x40 equals raw status (0x44) with mask-1 bits cleared.
- R4: With type bit 0 (level), a raw status bit is 1 exactly while the line is enabled and its filtered input equals its polarity bit (1 = active-high, 0 = active-low). It is not latched.
- R5: With type bit 1 (edge), a rising edge (polarity 1) or falling edge (polarity 0) on an enabled line sets its raw status bit. The bit stays set until cleared.
- R6: Writing 1 to a bit of 0x4C clears that line's latched edge status. Bits written 0 and level-mode lines are unaffected. An edge arriving in the same cycle keeps the bit set.
- R7: Disabling a line, or switching it to level mode, discards its latched edge status.
- R8: `irq_o` is the registered OR of the masked status. With debounce off, a level-mode input change shows on `irq_o` after exactly four rising clock edges.
- R9: With a line's debounce bit set, a new input value is accepted only after it has stayed stable for LEN prescaler ticks, with a length of 0 treated as 1. A tick occurs every DIV+1 clocks. A shorter pulse is discarded.
- R10: With all lines masked first, then mask ~0x0D, level type, all-ones polarity and enable 0x0D, only inputs 0, 2 and 3 can raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 32 | Asynchronous interrupt source lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
Faults in the stored state of a line show up in different ways:
- A stuck or lost edge latch appears in raw status at 0x44 a few cycles after the provoking input or end-of-interrupt write, and one cycle later on `irq_o`.
- A debounce counter or state that advances wrongly shows as an early or missing acceptance. The bench brackets this by sampling well before the earliest and well after the latest legal acceptance time.
- A stray extra or missing pipeline register shows as a one-cycle shift in the four-edge level latency, which is checked on exact edges.

The random phase compares both status registers and `irq_o` against a bench model after every configuration, input or end-of-interrupt change.

// File: rtl/gia_pkg.sv
package gia_pkg;
    localparam logic [7:0] OFS_EN     = 8'h30;
    localparam logic [7:0] OFS_MASK   = 8'h34;
    localparam logic [7:0] OFS_TYPE   = 8'h38;
    localparam logic [7:0] OFS_POL    = 8'h3C;
    localparam logic [7:0] OFS_MSTAT  = 8'h40;
    localparam logic [7:0] OFS_RSTAT  = 8'h44;
    localparam logic [7:0] OFS_DBEN   = 8'h48;
    localparam logic [7:0] OFS_EOI    = 8'h4C;
    localparam logic [7:0] OFS_DIV    = 8'h50;
    localparam logic [7:0] OFS_LEN    = 8'h54;

    typedef enum logic [0:0] {
        DB_STABLE = 1'b0,
        DB_SETTLE = 1'b1
    } db_state_e;
endpackage

// File: rtl/gia_sync.sv
module gia_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/gia_debounce.sv
module gia_debounce
    import gia_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             byp_i,
    input  logic             tick_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             filt_o
);
    db_state_e        state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             filt_q, filt_d;
    logic [LEN_W-1:0] limit;
    logic [LEN_W-1:0] cnt_inc;

    assign limit   = (len_i == '0) ? LEN_W'(1) : len_i;
    assign cnt_inc = cnt_q + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_STABLE;
            cnt_q   <= '0;
            filt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            filt_q  <= filt_d;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        filt_d  = filt_q;
        if (byp_i) begin
            state_d = DB_STABLE;            // bypass
            cnt_d   = '0;
            filt_d  = sync_i;
        end else begin
            unique case (state_q)
                DB_STABLE: begin
                    if (sync_i != filt_q) begin
                        state_d = DB_SETTLE;    // mismatch
                        cnt_d   = '0;
                    end
                end
                DB_SETTLE: begin
                    if (sync_i == filt_q) begin
                        state_d = DB_STABLE;    // glitch
                        cnt_d   = '0;
                    end else if (tick_i) begin
                        if (cnt_inc >= limit) begin
                            state_d = DB_STABLE; // accept
                            cnt_d   = '0;
                            filt_d  = sync_i;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                default: state_d = DB_STABLE;
            endcase
        end
    end

    assign filt_o = filt_q;
endmodule

// File: rtl/gia_detect.sv
module gia_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] filt_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] type_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] eoi_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] masked_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] latch_q;
    logic [N-1:0] rise, fall, hit, armed, lvl_act;

    assign rise    = filt_i & ~prev_q;
    assign fall    = ~filt_i & prev_q;
    assign hit     = (pol_i & rise) | (~pol_i & fall);
    assign armed   = en_i & type_i;
    assign lvl_act = en_i & ~type_i & ~(filt_i ^ pol_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= filt_i;
            latch_q <= armed & ((latch_q & ~eoi_i) | hit);
        end
    end

    assign raw_o    = lvl_act | (armed & latch_q);
    assign masked_o = raw_o & ~mask_i;
endmodule

// File: rtl/gia_regs.sv
module gia_regs
    import gia_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [N-1:0]      raw_i,
    input  logic [N-1:0]      masked_i,
    output logic [N-1:0]      en_o,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      type_o,
    output logic [N-1:0]      pol_o,
    output logic [N-1:0]      dben_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [N-1:0]      eoi_o
);
    logic [N-1:0]     en_q, mask_q, type_q, pol_q, dben_q;
    logic [DIV_W-1:0] div_q;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            type_q <= '0;
            pol_q  <= '0;
            dben_q <= '0;
            div_q  <= '0;
            len_q  <= '0;
        end else if (wr_i) begin
            if (addr_i == ADDR_W'(OFS_EN))   en_q   <= wdata_i[N-1:0];
            if (addr_i == ADDR_W'(OFS_MASK)) mask_q <= wdata_i[N-1:0];
            if (addr_i == ADDR_W'(OFS_TYPE)) type_q <= wdata_i[N-1:0];
            if (addr_i == ADDR_W'(OFS_POL))  pol_q  <= wdata_i[N-1:0];
            if (addr_i == ADDR_W'(OFS_DBEN)) dben_q <= wdata_i[N-1:0];
            if (addr_i == ADDR_W'(OFS_DIV))  div_q  <= wdata_i[DIV_W-1:0];
            if (addr_i == ADDR_W'(OFS_LEN))  len_q  <= wdata_i[LEN_W-1:0];
        end
    end

    assign eoi_o = (wr_i && addr_i == ADDR_W'(OFS_EOI)) ? wdata_i[N-1:0] : '0;

    always_comb begin
        rdata_o = '0;
        if      (addr_i == ADDR_W'(OFS_EN))    rdata_o = DATA_W'(en_q);
        else if (addr_i == ADDR_W'(OFS_MASK))  rdata_o = DATA_W'(mask_q);
        else if (addr_i == ADDR_W'(OFS_TYPE))  rdata_o = DATA_W'(type_q);
        else if (addr_i == ADDR_W'(OFS_POL))   rdata_o = DATA_W'(pol_q);
        else if (addr_i == ADDR_W'(OFS_DBEN))  rdata_o = DATA_W'(dben_q);
        else if (addr_i == ADDR_W'(OFS_DIV))   rdata_o = DATA_W'(div_q);
        else if (addr_i == ADDR_W'(OFS_LEN))   rdata_o = DATA_W'(len_q);
        else if (addr_i == ADDR_W'(OFS_RSTAT)) rdata_o = DATA_W'(raw_i);
        else if (addr_i == ADDR_W'(OFS_MSTAT)) rdata_o = DATA_W'(masked_i);
    end

    assign en_o   = en_q;
    assign mask_o = mask_q;
    assign type_o = type_q;
    assign pol_o  = pol_q;
    assign dben_o = dben_q;
    assign div_o  = div_q;
    assign len_o  = len_q;
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 8,
    parameter int DIV_W     = 16,
    parameter int LEN_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] gpio_in,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 irq_o
);
    localparam int DATA_W = 32;

    logic [NUM_LINES-1:0] sync_v, filt_v;
    logic [NUM_LINES-1:0] en_q, mask_q, type_q, pol_q, dben_q, eoi_v;
    logic [NUM_LINES-1:0] raw_stat, masked_stat;
    logic [DIV_W-1:0]     div_q, div_cnt;
    logic [LEN_W-1:0]     len_q;
    logic                 tick;
    logic                 irq_q;

    gia_sync #(.W(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(gpio_in), .q_o(sync_v)
    );

    // shared debounce tick prescaler
    assign tick = (div_cnt >= div_q);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        gia_debounce #(.LEN_W(LEN_W)) u_db (
            .clk(clk), .rst_n(rst_n), .sync_i(sync_v[i]), .byp_i(!dben_q[i]),
            .tick_i(tick), .len_i(len_q), .filt_o(filt_v[i])
        );
    end

    gia_regs #(
        .N(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata), .raw_i(raw_stat),
        .masked_i(masked_stat), .en_o(en_q), .mask_o(mask_q), .type_o(type_q),
        .pol_o(pol_q), .dben_o(dben_q), .div_o(div_q), .len_o(len_q), .eoi_o(eoi_v)
    );

    gia_detect #(.N(NUM_LINES)) u_det (
        .clk(clk), .rst_n(rst_n), .filt_i(filt_v), .en_i(en_q), .type_i(type_q),
        .pol_i(pol_q), .mask_i(mask_q), .eoi_i(eoi_v), .raw_o(raw_stat),
        .masked_o(masked_stat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |masked_stat;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
    parameter int NUM_LINES = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic                 irq_o,
    input logic [NUM_LINES-1:0] raw_stat,
    input logic [NUM_LINES-1:0] masked_stat,
    input logic [NUM_LINES-1:0] en_q,
    input logic [NUM_LINES-1:0] type_q,
    input logic [NUM_LINES-1:0] dben_q,
    input logic [NUM_LINES-1:0] sync_v,
    input logic [NUM_LINES-1:0] filt_v
);
    // R8: request rises one cycle after any masked event
    assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|masked_stat) |=> irq_o);

    // R8: request drops one cycle after masked status empties
    assert_irq_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|masked_stat) |=> !irq_o);

    // R3: no disabled line reaches masked status
    assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_stat & ~en_q) == '0);

    // R5: a latched edge bit never drops without a register write
    assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr) |->
        (($past(raw_stat) & $past(type_q) & type_q & $past(en_q) & en_q & ~raw_stat) == '0));

    // R9: lines without debounce follow the synchroniser with one register
    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_v ^ $past(sync_v)) & ~dben_q & ~$past(dben_q)) == '0);
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .irq_o(irq_o),
    .raw_stat(raw_stat), .masked_stat(masked_stat), .en_q(en_q),
    .type_q(type_q), .dben_q(dben_q), .sync_v(sync_v), .filt_v(filt_v)
);

// File: tb/gpio_irq_agg_tb.sv
module gpio_irq_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] gpio_in = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_en = '0, m_mask = '0, m_typ = '0, m_pol = '0, m_latch = '0;

    always #2.5 clk = ~clk;

    gpio_irq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    function automatic logic [31:0] f_raw();
        return (m_en & ~m_typ & ~(gpio_in ^ m_pol)) | (m_en & m_typ & m_latch);
    endfunction

    task automatic set_cfg(input logic [31:0] en, mask, typ, pol);
        wr(8'h30, en);
        m_latch &= en & m_typ;
        wr(8'h34, mask);
        wr(8'h38, typ);
        m_latch &= en & typ;
        wr(8'h3C, pol);
        m_en = en; m_mask = mask; m_typ = typ; m_pol = pol;
        settle();
    endtask

    task automatic set_gpio(input logic [31:0] v);
        logic [31:0] hit;
        @(negedge clk);
        hit = (m_pol & v & ~gpio_in) | (~m_pol & ~v & gpio_in);
        m_latch |= hit & m_en & m_typ;
        gpio_in = v;
        settle();
    endtask

    task automatic do_eoi(input logic [31:0] v);
        wr(8'h4C, v);
        m_latch &= ~v;
        settle();
    endtask

    task automatic check_model(input string tag);
        logic [31:0] d;
        logic [31:0] er;
        er = f_raw();
        rd(8'h44, d);
        check_eq({tag, " raw"}, d, er);
        rd(8'h40, d);
        check_eq({tag, " masked"}, d, er & ~m_mask);
        check_eq({tag, " irq"}, {31'd0, irq_o}, {31'd0, |(er & ~m_mask)});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        foreach (d[i]) begin end
        for (int a = 8'h30; a <= 8'h54; a += 4) begin
            rd(8'(a), d);
            check_eq($sformatf("R1 reset reg %h", a), d, 32'h0);
        end
        check_eq("R1 reset irq", {31'd0, irq_o}, 32'd0);

        // R2: register map
        wr(8'h30, 32'hA5A5_0F0F); rd(8'h30, d); check_eq("R2 enable", d, 32'hA5A5_0F0F);
        wr(8'h34, 32'h1234_5678); rd(8'h34, d); check_eq("R2 mask", d, 32'h1234_5678);
        wr(8'h38, 32'hFFFF_0000); rd(8'h38, d); check_eq("R2 type", d, 32'hFFFF_0000);
        wr(8'h3C, 32'h0F0F_F0F0); rd(8'h3C, d); check_eq("R2 polarity", d, 32'h0F0F_F0F0);
        wr(8'h48, 32'h8000_0001); rd(8'h48, d); check_eq("R2 debounce en", d, 32'h8000_0001);
        wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, d); check_eq("R2 divider", d, 32'h0000_FFFF);
        wr(8'h54, 32'hFFFF_FFFF); rd(8'h54, d); check_eq("R2 length", d, 32'h0000_00FF);
        wr(8'h4C, 32'hFFFF_FFFF); rd(8'h4C, d); check_eq("R2 eoi reads zero", d, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check_eq("R2 unmapped", d, 32'h0);
        wr(8'h48, 32'h0); wr(8'h50, 32'h0); wr(8'h54, 32'h0);
        set_cfg(32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF);

        // R8: exact level latency, line 5 active-high
        set_cfg(32'h20, 32'h0, 32'h0, 32'hFFFF_FFFF);
        @(negedge clk);
        gpio_in[5] = 1'b1;
        repeat (3) @(posedge clk);
        #1 check_eq("R8 irq low after 3 edges", {31'd0, irq_o}, 32'd0);
        @(posedge clk);
        #1 check_eq("R8 irq high after 4 edges", {31'd0, irq_o}, 32'd1);
        settle();
        check_model("R4 level active-high");

        // R3: masking stops the request, enable still set
        set_cfg(32'h20, 32'h20, 32'h0, 32'hFFFF_FFFF);
        check_model("R3 masked line");
        set_gpio(32'h0);

        // R4: active-low level
        set_cfg(32'h1, 32'h0, 32'h0, 32'h0);
        check_model("R4 active-low asserted");
        set_gpio(32'h1);
        check_model("R4 active-low released");

        // R6: end-of-interrupt does not affect level lines
        set_gpio(32'h0);
        do_eoi(32'hFFFF_FFFF);
        check_model("R6 level survives eoi");

        // R5: rising edge latch and clear
        set_cfg(32'h2, 32'h0, 32'h2, 32'h2);
        set_gpio(32'h2);
        set_gpio(32'h0);
        check_model("R5 rising latched after release");
        do_eoi(32'h1);
        check_model("R6 eoi on other bit keeps latch");
        do_eoi(32'h2);
        check_model("R6 eoi clears latch");

        // R5: falling edge mode
        set_cfg(32'h2, 32'h0, 32'h2, 32'h0);
        set_gpio(32'h2);
        check_model("R5 rise ignored in falling mode");
        set_gpio(32'h0);
        check_model("R5 falling latched");

        // R7: disable discards latch
        set_cfg(32'h0, 32'h0, 32'h2, 32'h0);
        set_cfg(32'h2, 32'h0, 32'h2, 32'h0);
        check_model("R7 latch gone after disable");
        set_gpio(32'h2); set_gpio(32'h0);
        set_cfg(32'h2, 32'h0, 32'h0, 32'h2);
        set_cfg(32'h2, 32'h0, 32'h2, 32'h0);
        check_model("R7 latch gone after level mode");

        // R10: typical wiring of lines 0, 2, 3
        set_cfg(32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0);
        set_cfg(32'h0, ~32'h0D, 32'h0, 32'hFFFF_FFFF);
        set_cfg(32'h0D, ~32'h0D, 32'h0, 32'hFFFF_FFFF);
        set_gpio(32'h2);
        check_eq("R10 line1 blocked", {31'd0, irq_o}, 32'd0);
        set_gpio(32'h8);
        check_eq("R10 line3 raises", {31'd0, irq_o}, 32'd1);
        rd(8'h40, d);
        check_eq("R10 masked status", d, 32'h8);
        set_gpio(32'h0);

        // R9: debounce on line 0, tick every 4 clocks, 4 ticks
        set_cfg(32'h1, 32'h0, 32'h0, 32'hFFFF_FFFF);
        wr(8'h50, 32'd3); wr(8'h54, 32'd4); wr(8'h48, 32'h1);
        settle();
        @(negedge clk); gpio_in[0] = 1'b1;
        repeat (5) @(negedge clk); gpio_in[0] = 1'b0;
        repeat (30) @(negedge clk);
        check_eq("R9 short pulse rejected", {31'd0, irq_o}, 32'd0);
        @(negedge clk); gpio_in[0] = 1'b1;
        repeat (8) @(negedge clk);
        check_eq("R9 not accepted early", {31'd0, irq_o}, 32'd0);
        repeat (22) @(negedge clk);
        check_eq("R9 accepted after stable window", {31'd0, irq_o}, 32'd1);
        wr(8'h48, 32'h0); wr(8'h50, 32'h0); wr(8'h54, 32'h0);
        set_gpio(32'h0);

        // random phase against the model
        for (int it = 0; it < 80; it++) begin
            int unsigned op;
            op = $urandom_range(0, 2);
            if (op == 0)
                set_cfg($urandom(), $urandom(), $urandom(), $urandom());
            else if (op == 1)
                set_gpio($urandom());
            else
                do_eoi($urandom());
            check_model($sformatf("R3/R4/R5/R6 random step %0d", it));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule